// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

The block keeps a 32-bit count of elapsed seconds and advances it by one on every cycle in which the one-second tick input is high. Software reaches it through a small 16-bit register bus. A write on the bus takes effect at the clock edge. Read data is a combinational function of the address.

Software sets a new time in two steps. It first writes the upper half, then the lower half. The write of the lower half arms a pending update, and the staged 32-bit value replaces the running count at the next tick. A busy flag covers the time between that write and the load. A valid flag shows that a time has been loaded at least once. A 16-bit write counter counts the loads.

A 32-bit alarm value is compared against the running count. On entry into a match while the alarm is enabled, the block raises a one-cycle interrupt pulse and sets a sticky status bit, which software clears by writing 1. A frequency field and a trim field are stored and read back only.

Register map (3-bit address): 0 time upper half (count bits 31:16), 1 time lower half (bits 15:0), 2 alarm upper half, 3 alarm lower half, 4 control/status, 5 write counter, 6 trim. Control/status bits: 15 valid (read-only), 14 busy (read-only), 10 alarm enable, 6:4 frequency field, 0 alarm status (write 1 to clear). All other bits read 0.

Top module: `sec_rtc`

## Requirements
- R1: After reset, every register address (0 to 6) reads 0 and irq_o is low.
- R2: Address 0 reads the running count bits 31:16 and address 1 reads bits 15:0. The count rises by one per tick_i cycle, wraps from FFFFFFFF to 0, and does not change without a tick.
- R3: Writes to address 0 and then address 1 stage a time without changing the running count. The write to address 1 sets busy (control bit 14) from the next cycle. At the first tick after that write, the count takes the staged value exactly and busy clears. A tick in the same cycle as the address-1 write only increments the old count, and the load happens at the following tick.
- R4: Valid (control bit 15) reads 0 until the first staged load and reads 1 from then until reset.
- R5: The write counter (address 5) increases by exactly one on each staged load.
- R6: Addresses 2 and 3 store the alarm bits 31:16 and 15:0 and read them back.
- R7: irq_o is high for exactly one cycle when the count becomes equal to the alarm value while the alarm enable (control bit 10) is 1. This includes the case where the enable is set while the two are already equal. No pulse occurs while the enable is 0.
- R8: Each irq_o pulse sets the status bit (control bit 0). Writing control with bit 0 = 1 clears it, and writing bit 0 = 0 leaves it unchanged. A pulse in the same cycle as a clearing write leaves the bit set.
- R9: Control bits 6:4 and trim bits 9:0 (address 6) hold the last written value. The upper trim bits read 0.
- R10: Writes to control bits 15 and 14 and to address 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick, one cycle wide |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Alarm interrupt pulse |

## Verification
Two pairs of events can fall in one cycle. In the first, a tick arrives in the same cycle as the write that arms a time load. The bench drives tick_i together with that write and expects a plain increment, a raised busy flag, and the staged value at the following tick. In the second, an alarm pulse coincides with a status-clearing write. The bench times a write-1-to-clear into the cycle where irq_o is high and expects the status bit to read 1 afterwards. A sweep over alarm offsets, with the enable on and off, counts pulses against a value computed in the bench.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 3;

  typedef enum logic [AW-1:0] {
    A_TIME_HI = 3'd0,
    A_TIME_LO = 3'd1,
    A_ALM_HI  = 3'd2,
    A_ALM_LO  = 3'd3,
    A_CTRL    = 3'd4,
    A_WCNT    = 3'd5,
    A_TRIM    = 3'd6
  } reg_addr_e;

  localparam int unsigned B_VALID  = 15;
  localparam int unsigned B_BUSY   = 14;
  localparam int unsigned B_ALM_EN = 10;
  localparam int unsigned B_FREQ   = 4;
  localparam int unsigned B_STAT   = 0;
endpackage

// File: rtl/rtc_sec_counter.sv
`timescale 1ns/1ps
module rtc_sec_counter #(
  parameter int unsigned DW   = 16,
  parameter int unsigned TW   = 32,
  parameter int unsigned WC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [TW/DW-1:0] stage_we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [TW-1:0]   cnt_o,
  output logic            busy_o,
  output logic            valid_o,
  output logic [WC_W-1:0] wcnt_o
);
  localparam int unsigned NH = TW / DW;

  logic [TW-1:0] staged;
  logic          pend_q;

  for (genvar h = 0; h < NH; h++) begin : g_half
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            q <= '0;
      else if (stage_we_i[h]) q <= wdata_i;
    end
    assign staged[h*DW +: DW] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      pend_q  <= 1'b0;
      valid_o <= 1'b0;
      wcnt_o  <= '0;
    end else begin
      if (tick_i) begin
        if (pend_q) begin
          cnt_o   <= staged;
          pend_q  <= 1'b0;
          valid_o <= 1'b1;
          wcnt_o  <= wcnt_o + 1'b1;
        end else begin
          cnt_o <= cnt_o + 1'b1;
        end
      end
      // low half write arms a load; a re-arm wins over a same-edge commit
      if (stage_we_i[0]) pend_q <= 1'b1;
    end
  end

  assign busy_o = pend_q;
endmodule

// File: rtl/rtc_alarm_cmp.sv
`timescale 1ns/1ps
module rtc_alarm_cmp #(
  parameter int unsigned TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] cnt_i,
  input  logic [TW-1:0] alarm_i,
  input  logic          en_i,
  input  logic          stat_clr_i,
  output logic          irq_o,
  output logic          stat_o
);
  logic match, match_q;

  assign match = en_i && (cnt_i == alarm_i);
  assign irq_o = match && !match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      stat_o  <= 1'b0;
    end else begin
      match_q <= match;
      if (irq_o)           stat_o <= 1'b1;
      else if (stat_clr_i) stat_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_bus_regs.sv
`timescale 1ns/1ps
module rtc_bus_regs
  import rtc_pkg::*;
#(
  parameter int unsigned TW     = 32,
  parameter int unsigned WC_W   = 16,
  parameter int unsigned FREQ_W = 3,
  parameter int unsigned TRIM_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [TW-1:0]   cnt_i,
  input  logic            busy_i,
  input  logic            valid_i,
  input  logic [WC_W-1:0] wcnt_i,
  input  logic            stat_i,
  output logic [TW/DW-1:0] stage_we_o,
  output logic [TW-1:0]   alarm_o,
  output logic            alm_en_o,
  output logic            stat_clr_o,
  output logic [DW-1:0]   rdata_o
);
  localparam int unsigned NH = TW / DW;

  logic              wr;
  logic [FREQ_W-1:0] freq_q;
  logic [TRIM_W-1:0] trim_q;
  logic [NH-1:0]     alm_we;

  assign wr = req_i && we_i;

  // half h sits at base + (NH-1-h): upper half first
  for (genvar h = 0; h < NH; h++) begin : g_dec
    localparam logic [AW-1:0] TA = AW'(A_TIME_HI) + AW'(NH - 1 - h);
    localparam logic [AW-1:0] AA = AW'(A_ALM_HI) + AW'(NH - 1 - h);
    assign stage_we_o[h] = wr && (addr_i == TA);
    assign alm_we[h]     = wr && (addr_i == AA);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        alarm_o[h*DW +: DW] <= '0;
      else if (alm_we[h]) alarm_o[h*DW +: DW] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_en_o <= 1'b0;
      freq_q   <= '0;
      trim_q   <= '0;
    end else if (wr) begin
      if (addr_i == A_CTRL) begin
        alm_en_o <= wdata_i[B_ALM_EN];
        freq_q   <= wdata_i[B_FREQ +: FREQ_W];
      end
      if (addr_i == A_TRIM) trim_q <= wdata_i[TRIM_W-1:0];
    end
  end

  assign stat_clr_o = wr && (addr_i == A_CTRL) && wdata_i[B_STAT];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_TIME_HI: rdata_o = cnt_i[TW-1 -: DW];
      A_TIME_LO: rdata_o = cnt_i[DW-1:0];
      A_ALM_HI:  rdata_o = alarm_o[TW-1 -: DW];
      A_ALM_LO:  rdata_o = alarm_o[DW-1:0];
      A_CTRL: begin
        rdata_o[B_VALID]           = valid_i;
        rdata_o[B_BUSY]            = busy_i;
        rdata_o[B_ALM_EN]          = alm_en_o;
        rdata_o[B_FREQ +: FREQ_W]  = freq_q;
        rdata_o[B_STAT]            = stat_i;
      end
      A_WCNT:    rdata_o[WC_W-1:0]   = wcnt_i;
      A_TRIM:    rdata_o[TRIM_W-1:0] = trim_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sec_rtc.sv
`timescale 1ns/1ps
module sec_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned TW     = 32,
  parameter int unsigned WC_W   = 16,
  parameter int unsigned FREQ_W = 3,
  parameter int unsigned TRIM_W = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam int unsigned NH = TW / DW;

  logic [TW-1:0]   cnt, alarm;
  logic [NH-1:0]   stage_we;
  logic            busy, valid, alm_en, status, stat_clr;
  logic [WC_W-1:0] wcnt;

  rtc_bus_regs #(.TW(TW), .WC_W(WC_W), .FREQ_W(FREQ_W), .TRIM_W(TRIM_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .busy_i(busy), .valid_i(valid), .wcnt_i(wcnt), .stat_i(status),
    .stage_we_o(stage_we), .alarm_o(alarm), .alm_en_o(alm_en),
    .stat_clr_o(stat_clr), .rdata_o
  );

  rtc_sec_counter #(.DW(DW), .TW(TW), .WC_W(WC_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .stage_we_i(stage_we), .wdata_i,
    .cnt_o(cnt), .busy_o(busy), .valid_o(valid), .wcnt_o(wcnt)
  );

  rtc_alarm_cmp #(.TW(TW)) u_alm (
    .clk_i, .rst_ni, .cnt_i(cnt), .alarm_i(alarm), .en_i(alm_en),
    .stat_clr_i(stat_clr), .irq_o, .stat_o(status)
  );
endmodule

// File: rtl/rtc_checker.sv
`timescale 1ns/1ps
module rtc_checker
  import rtc_pkg::*;
#(
  parameter int unsigned TW   = 32,
  parameter int unsigned WC_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic            req_i,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic            irq_o,
  input logic [TW-1:0]   cnt,
  input logic            busy,
  input logic            valid,
  input logic            alm_en,
  input logic            status,
  input logic [WC_W-1:0] wcnt
);
  p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt));
  p_busy_after_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_TIME_LO) |=> busy);
  p_valid_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid |=> valid);
  p_wcnt_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && tick_i) |=> (wcnt == $past(wcnt) + 1'b1));
  p_irq_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_irq_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> alm_en);
  p_status_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> status);
endmodule

bind sec_rtc rtc_checker #(.TW(TW), .WC_W(WC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .irq_o(irq_o), .cnt(cnt), .busy(busy), .valid(valid),
  .alm_en(alm_en), .status(status), .wcnt(wcnt)
);

// File: tb/sim_sec_rtc.sv
`timescale 1ns/1ps
module sim_sec_rtc;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        irq;
  int checks = 0, fails = 0, irq_seen = 0, exp_wc = 0;

  sec_rtc u0 (.clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
              .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  always #2.5 clk = ~clk;
  always @(posedge clk) if (irq) irq_seen++;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic rd_time(output logic [31:0] t);
    logic [15:0] h, l;
    rd(3'd0, h); rd(3'd1, l); t = {h, l};
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic set_time(input logic [31:0] v);
    logic [15:0] c; logic [31:0] t;
    wr(3'd0, v[31:16]); wr(3'd1, v[15:0]);
    rd(3'd4, c); chk("R3 busy set", 32'(c[14]), 1);
    do_tick(); exp_wc++;
    rd_time(t); chk("R3 load exact", t, v);
    rd(3'd4, c); chk("R3 busy clear", 32'(c[14]), 0);
    chk("R4 valid", 32'(c[15]), 1);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v; logic [31:0] t; int base_irq;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 7; a++) begin rd(3'(a), v); chk("R1 reset reg", 32'(v), 0); end
    chk("R1 irq low", 32'(irq), 0);

    for (int i = 0; i < 5; i++) do_tick();
    rd_time(t); chk("R2 tick count", t, 5);
    repeat (4) @(negedge clk);
    rd_time(t); chk("R2 hold without tick", t, 5);

    for (int f = 0; f < 8; f++) begin
      wr(3'd4, 16'(f << 4)); rd(3'd4, v); chk("R9 freq field", 32'(v), 32'(f << 4));
    end
    foreach (v[i]) ;
    begin
      logic [15:0] tv [5] = '{16'h0000, 16'h03FF, 16'h0155, 16'h02AA, 16'hFFFF};
      foreach (tv[i]) begin
        wr(3'd6, tv[i]); rd(3'd6, v); chk("R9 trim", 32'(v), 32'(tv[i] & 16'h03FF));
      end
    end
    wr(3'd4, 16'hC000); rd(3'd4, v); chk("R10 ctrl ro bits", 32'(v), 0);
    wr(3'd5, 16'h1234); rd(3'd5, v); chk("R10 wcnt write ignored", 32'(v), 0);

    wr(3'd0, 16'hABCD); wr(3'd1, 16'h1234);
    rd_time(t); chk("R3 staged not live", t, 5);
    rd(3'd4, v); chk("R4 valid before load", 32'(v[15]), 0);
    do_tick(); exp_wc++;
    rd_time(t); chk("R3 first load", t, 32'hABCD1234);
    rd(3'd5, v); chk("R5 wcnt first", 32'(v), 32'(exp_wc));

    // tick in the arming cycle
    wr(3'd0, 16'h0000);
    @(negedge clk); req = 1; we = 1; addr = 3'd1; wdata = 16'h0100; tick = 1;
    @(negedge clk); req = 0; we = 0; tick = 0;
    rd_time(t); chk("R3 same-cycle tick increments", t, 32'hABCD1235);
    rd(3'd4, v); chk("R3 busy after same-cycle", 32'(v[14]), 1);
    do_tick(); exp_wc++;
    rd_time(t); chk("R3 deferred load", t, 32'h00000100);

    set_time(32'hFFFFFFFF); do_tick();
    rd_time(t); chk("R2 wrap", t, 0);
    set_time(32'h0000FFFF); do_tick();
    rd_time(t); chk("R2 half carry", t, 32'h00010000);

    for (int i = 0; i < 20; i++) begin
      set_time(32'h1000 * i + 7);
      rd(3'd5, v); chk("R5 wcnt step", 32'(v), 32'(exp_wc));
    end

    for (int en = 0; en < 2; en++) begin
      for (int k = 0; k < 5; k++) begin
        logic [31:0] b = 32'h5000_0000 + 32'(k * 97 + en * 3);
        wr(3'd4, 16'h0001);
        set_time(b);
        wr(3'd2, 16'((b + 32'(k)) >> 16)); wr(3'd3, 16'(b + 32'(k)));
        rd(3'd2, v); chk("R6 alarm hi", 32'(v), (b + 32'(k)) >> 16);
        rd(3'd3, v); chk("R6 alarm lo", 32'(v), (b + 32'(k)) & 32'hFFFF);
        base_irq = irq_seen;
        wr(3'd4, 16'(en << 10));
        for (int j = 0; j <= k; j++) do_tick();
        repeat (3) @(negedge clk);
        chk("R7 pulse count", 32'(irq_seen - base_irq), 32'(en));
        rd(3'd4, v); chk("R8 status", 32'(v[0]), 32'(en));
        rd_time(t); chk("R2 after sweep", t, b + 32'(k) + 1);
      end
    end

    wr(3'd4, 16'h0400); rd(3'd4, v); chk("R8 write 0 keeps", 32'(v[0]), 1);
    wr(3'd4, 16'h0401); rd(3'd4, v); chk("R8 w1c clears", 32'(v[0]), 0);

    // pulse and clear in the same cycle
    wr(3'd4, 16'h0001);
    set_time(32'h0000_2000);
    wr(3'd2, 16'h0000); wr(3'd3, 16'h2001);
    wr(3'd4, 16'h0400);
    base_irq = irq_seen;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; chk("R7 irq high after tick", 32'(irq), 1);
    req = 1; we = 1; addr = 3'd4; wdata = 16'h0401;
    @(negedge clk); req = 0; we = 0;
    rd(3'd4, v); chk("R8 set wins over clear", 32'(v[0]), 1);
    chk("R7 single pulse", 32'(irq_seen - base_irq), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule